// File: doc/BRIEF.md
# Predicated Dataflow Instruction Window

This block holds the instructions of one dataflow block, each in its own numbered slot. Each instruction waits until its operands have arrived and, if it is predicated, until a matching predicate has arrived. It then issues exactly once to a single execution port. There is no shared register file. The result of an issued instruction is written straight into the operand slots of at most two consumer instructions named inside its own instruction word. Values with more than two consumers are spread through move instructions, which copy their left operand to their own two targets.

Loading happens one slot per cycle. Execution starts when outside values are injected into the slots that read them. A predicated instruction whose predicate has the wrong polarity never fires. Any instruction downstream of it that lacks an operand stays quiet too. A flush empties the whole window in one cycle. A small combinational arithmetic stub sits at the execution port, so the result appears in the same cycle as the issue.

Top module: `dataflow_window`

## Requirements
- R1: Out of reset no slot holds an instruction, and `issueValid` is low.
- R2: `loadWord` packs the instruction fields at fixed bit positions (with 4-bit slot numbers): op [1:0], predicate enable [2], required polarity [3], first target slot [7:4], first target operand index [9:8], first target enable [10], second target slot [14:11], second target operand index [16:15], second target enable [17]. Loading a slot stores the word, makes it live, and clears its operand, predicate and fired state.
- R3: A delivery (`injIdx` or a target index) selects left operand with 0, right operand with 1 and predicate with 2, where the predicate value is bit 0 of the data. Index 3 is ignored.
- R4: A live slot issues at most once until it is reloaded.
- R5: At most one slot issues per cycle, and among ready slots the lowest-numbered one is chosen.
- R6: `issueResult` shows, in the issue cycle, left+right for op 0, left-right for op 1, left XOR right for op 2, and left alone for op 3 (move). Move needs no right operand.
- R7: An issued result is written to each enabled target at the next clock edge, so a consumer can issue one cycle after its producer at the earliest.
- R8: A predicated slot issues only after it has received a predicate equal to its polarity. On a mismatch it never issues.
- R9: A slot missing a required operand never issues.
- R10: A flush empties every slot and clears every fired bit in one cycle. Loads and deliveries in the flush cycle are ignored, and an emptied slot does not issue even if operands arrive later.
- R11: When deliveries collide on one operand in the same cycle, the injected value beats a forwarded one. A load to a slot beats any delivery to that slot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty the whole window |
| loadValid | input | 1 | Load `loadWord` into `loadSlot` |
| loadSlot | input | SLOT_W | Slot being loaded |
| loadWord | input | INSTR_W | Packed instruction word |
| injValid | input | 1 | Outside operand or predicate delivery |
| injSlot | input | SLOT_W | Destination slot of the delivery |
| injIdx | input | 2 | Destination operand index |
| injData | input | DATA_W | Delivered value |
| issueValid | output | 1 | A slot issues this cycle |
| issueSlot | output | SLOT_W | Number of the issuing slot |
| issueResult | output | DATA_W | Stub result that is forwarded to the targets |

## Verification
The hardest case to reach from the ports is two slots that become ready in the same cycle. Injection only feeds one operand per cycle, so the bench uses a move producer whose two targets fill two consumers at once. The other hard case is a forwarded value and an injected value landing on the same operand in the same edge. The bench times an injection into the consumer for the cycle in which its producer issues. On top of these directed cases, a seeded random phase loads random words and injects random deliveries, with occasional flushes. Every cycle is compared against a slot-level model kept in the bench.

// File: rtl/dfw_pkg.sv
package dfw_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_XOR = 2'd2,
    OP_MOV = 2'd3
  } opKind_e;

  // operand index codes carried by deliveries
  localparam logic [1:0] IDX_LEFT  = 2'd0;
  localparam logic [1:0] IDX_RIGHT = 2'd1;
  localparam logic [1:0] IDX_PRED  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic issueEn;
    logic flushEn;
  } ctrlStrobe_t;
endpackage

// File: rtl/dfw_control.sv
module dfw_control
  import dfw_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flush,
  input  logic                 loadValid,
  input  logic [SLOT_W-1:0]    loadSlot,
  input  logic [NUM_SLOTS-1:0] readyVec,
  output ctrlStrobe_t          strobe,
  output logic [SLOT_W-1:0]    issueSlot
);
  logic [NUM_SLOTS-1:0] firedQ, firedD, candVec;
  logic                 anyCand;
  logic [SLOT_W-1:0]    pickSlot;

  assign candVec = readyVec & ~firedQ;
  assign anyCand = |candVec;

  // lowest-numbered candidate wins: scan downwards, last hit stays
  always_comb begin
    pickSlot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (candVec[i]) pickSlot = SLOT_W'(i);
    end
  end

  always_comb begin
    firedD = firedQ;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (loadValid && loadSlot == SLOT_W'(i)) firedD[i] = 1'b0;
      else if (anyCand && pickSlot == SLOT_W'(i)) firedD[i] = 1'b1;
    end
    if (flush) firedD = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) firedQ <= '0;
    else       firedQ <= firedD;
  end

  assign strobe.issueEn = anyCand;
  assign strobe.flushEn = flush;
  assign issueSlot      = pickSlot;

  // R4: a slot just issued cannot issue again on the next cycle
  p_fire_once_r4: assert property (@(posedge clk) disable iff (!rstN)
    (anyCand && !flush && !(loadValid && loadSlot == pickSlot))
      |=> !(strobe.issueEn && issueSlot == $past(pickSlot)));

  // R10: the cycle after a flush nothing is left to issue
  p_flush_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !strobe.issueEn);
endmodule

// File: rtl/dfw_datapath.sv
module dfw_datapath
  import dfw_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 16,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int INSTR_W   = 4 + 2 * (3 + SLOT_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [SLOT_W-1:0]    issueSlot,
  input  logic                 loadValid,
  input  logic [SLOT_W-1:0]    loadSlot,
  input  logic [INSTR_W-1:0]   loadWord,
  input  logic                 injValid,
  input  logic [SLOT_W-1:0]    injSlot,
  input  logic [1:0]           injIdx,
  input  logic [DATA_W-1:0]    injData,
  output logic [NUM_SLOTS-1:0] readyVec,
  output logic [DATA_W-1:0]    issueResult
);
  localparam int T0_LSB = 4;
  localparam int T1_LSB = T0_LSB + SLOT_W + 3;

  logic [INSTR_W-1:0]   wordQ  [NUM_SLOTS];
  logic [DATA_W-1:0]    leftQ  [NUM_SLOTS];
  logic [DATA_W-1:0]    rightQ [NUM_SLOTS];
  logic [2:0]           vldQ   [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] loadedQ, predBitQ;

  logic [2:0]           wrEn [NUM_SLOTS];
  logic [DATA_W-1:0]    wrD  [NUM_SLOTS][3];

  logic [INSTR_W-1:0] selWord;
  logic [DATA_W-1:0]  aluA, aluB;
  logic               fwd0En, fwd1En;
  logic [SLOT_W-1:0]  t0Slot, t1Slot;
  logic [1:0]         t0Idx, t1Idx;

  assign selWord = wordQ[issueSlot];
  assign aluA    = leftQ[issueSlot];
  assign aluB    = rightQ[issueSlot];
  assign t0Slot  = selWord[T0_LSB +: SLOT_W];
  assign t0Idx   = selWord[T0_LSB + SLOT_W +: 2];
  assign fwd0En  = strobe.issueEn && selWord[T0_LSB + SLOT_W + 2];
  assign t1Slot  = selWord[T1_LSB +: SLOT_W];
  assign t1Idx   = selWord[T1_LSB + SLOT_W +: 2];
  assign fwd1En  = strobe.issueEn && selWord[T1_LSB + SLOT_W + 2];

  // execution stub
  always_comb begin
    unique case (opKind_e'(selWord[1:0]))
      OP_ADD:  issueResult = aluA + aluB;
      OP_SUB:  issueResult = aluA - aluB;
      OP_XOR:  issueResult = aluA ^ aluB;
      default: issueResult = aluA;
    endcase
  end

  // operand writes: later checks override earlier ones (injection last)
  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      wrEn[i] = '0;
      for (int k = 0; k < 3; k++) begin
        wrD[i][k] = '0;
        if (fwd0En && t0Slot == SLOT_W'(i) && t0Idx == 2'(k)) begin
          wrEn[i][k] = 1'b1;
          wrD[i][k]  = issueResult;
        end
        if (fwd1En && t1Slot == SLOT_W'(i) && t1Idx == 2'(k)) begin
          wrEn[i][k] = 1'b1;
          wrD[i][k]  = issueResult;
        end
        if (injValid && injSlot == SLOT_W'(i) && injIdx == 2'(k)) begin
          wrEn[i][k] = 1'b1;
          wrD[i][k]  = injData;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadedQ  <= '0;
      predBitQ <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        wordQ[i]  <= '0;
        leftQ[i]  <= '0;
        rightQ[i] <= '0;
        vldQ[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (strobe.flushEn) begin
          loadedQ[i] <= 1'b0;
          vldQ[i]    <= '0;
        end else if (loadValid && loadSlot == SLOT_W'(i)) begin
          wordQ[i]   <= loadWord;
          loadedQ[i] <= 1'b1;
          vldQ[i]    <= '0;
        end else begin
          vldQ[i] <= vldQ[i] | wrEn[i];
          if (wrEn[i][0]) leftQ[i]    <= wrD[i][0];
          if (wrEn[i][1]) rightQ[i]   <= wrD[i][1];
          if (wrEn[i][2]) predBitQ[i] <= wrD[i][2][0];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      readyVec[i] = loadedQ[i] && vldQ[i][0]
        && (opKind_e'(wordQ[i][1:0]) == OP_MOV || vldQ[i][1])
        && (!wordQ[i][2] || (vldQ[i][2] && predBitQ[i] == wordQ[i][3]));
    end
  end

  // R5: control only picks a slot the datapath reports ready
  p_pick_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueEn |-> readyVec[issueSlot]);

  // R7: the first target operand holds a value after the forwarding edge
  p_fwd_lands_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fwd0En && !strobe.flushEn && t0Idx != 2'd3 && !(loadValid && loadSlot == t0Slot))
      |=> vldQ[$past(t0Slot)][$past(t0Idx)]);
endmodule

// File: rtl/dataflow_window.sv
module dataflow_window
  import dfw_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int INSTR_W  = 4 + 2 * (3 + SLOT_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               loadValid,
  input  logic [SLOT_W-1:0]  loadSlot,
  input  logic [INSTR_W-1:0] loadWord,
  input  logic               injValid,
  input  logic [SLOT_W-1:0]  injSlot,
  input  logic [1:0]         injIdx,
  input  logic [DATA_W-1:0]  injData,
  output logic               issueValid,
  output logic [SLOT_W-1:0]  issueSlot,
  output logic [DATA_W-1:0]  issueResult
);
  ctrlStrobe_t          strobe;
  logic [NUM_SLOTS-1:0] readyVec;

  dfw_control #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush),
    .loadValid(loadValid), .loadSlot(loadSlot),
    .readyVec(readyVec), .strobe(strobe), .issueSlot(issueSlot)
  );

  dfw_datapath #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .SLOT_W(SLOT_W),
                 .INSTR_W(INSTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .issueSlot(issueSlot),
    .loadValid(loadValid), .loadSlot(loadSlot), .loadWord(loadWord),
    .injValid(injValid), .injSlot(injSlot), .injIdx(injIdx), .injData(injData),
    .readyVec(readyVec), .issueResult(issueResult)
  );

  assign issueValid = strobe.issueEn;
endmodule

// File: tb/dataflow_window_tb.sv
module dataflow_window_tb;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0, loadValid = 1'b0, injValid = 1'b0;
  logic [3:0]  loadSlot = '0, injSlot = '0;
  logic [17:0] loadWord = '0;
  logic [1:0]  injIdx = '0;
  logic [15:0] injData = '0;
  logic        issueValid;
  logic [3:0]  issueSlot;
  logic [15:0] issueResult;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dataflow_window u_dut (
    .clk(clk), .rstN(rstN), .flush(flush), .loadValid(loadValid),
    .loadSlot(loadSlot), .loadWord(loadWord), .injValid(injValid),
    .injSlot(injSlot), .injIdx(injIdx), .injData(injData),
    .issueValid(issueValid), .issueSlot(issueSlot), .issueResult(issueResult)
  );

  // bench model of the window, built from the requirements
  logic [17:0] mWord [NS];
  logic [15:0] mLeft [NS], mRight [NS];
  logic [2:0]  mVld [NS];
  logic        mLoaded [NS], mFired [NS], mPred [NS];

  function automatic logic [17:0] mkWord(input logic [1:0] op, input logic pe, pp,
      input logic v0, input logic [1:0] i0, input logic [3:0] s0,
      input logic v1, input logic [1:0] i1, input logic [3:0] s1);
    return {v1, i1, s1, v0, i0, s0, pp, pe, op};
  endfunction

  function automatic logic [15:0] aluRef(input logic [1:0] op, input logic [15:0] a, b);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a ^ b;
      default: return a;
    endcase
  endfunction

  function automatic bit readyRef(input int i);
    return mLoaded[i] && !mFired[i] && mVld[i][0]
      && (mWord[i][1:0] == 2'd3 || mVld[i][1])
      && (!mWord[i][2] || (mVld[i][2] && mPred[i] == mWord[i][3]));
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic reportEnd();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < NS; i++) begin
      mWord[i] = '0; mLeft[i] = '0; mRight[i] = '0; mVld[i] = '0;
      mLoaded[i] = 0; mFired[i] = 0; mPred[i] = 0;
    end
  endtask

  task automatic deliver(input int s, input logic [1:0] idx, input logic [15:0] d);
    if (loadValid && int'(loadSlot) == s) return;
    case (idx)
      2'd0: begin mLeft[s] = d; mVld[s][0] = 1'b1; end
      2'd1: begin mRight[s] = d; mVld[s][1] = 1'b1; end
      2'd2: begin mPred[s] = d[0]; mVld[s][2] = 1'b1; end
      default: ;
    endcase
  endtask

  // called at a falling edge with inputs already driven: check, update model, advance
  task automatic cycle(input string tag);
    int pick = -1;
    logic [15:0] res;
    logic [17:0] w;
    for (int i = NS - 1; i >= 0; i--) if (readyRef(i)) pick = i;
    check(issueValid == (pick >= 0), tag, "issueValid", 32'(issueValid), 32'(pick >= 0));
    if (pick >= 0 && issueValid) begin
      w = mWord[pick];
      res = aluRef(w[1:0], mLeft[pick], mRight[pick]);
      check(issueSlot == 4'(pick) && issueResult == res, tag, "slot/result",
            {12'd0, issueSlot, issueResult}, {12'd0, 4'(pick), res});
    end
    if (flush) begin
      for (int i = 0; i < NS; i++) begin mLoaded[i] = 0; mVld[i] = '0; mFired[i] = 0; end
    end else begin
      if (pick >= 0) begin
        mFired[pick] = 1;
        if (w[10]) deliver(int'(w[7:4]), w[9:8], res);
        if (w[17]) deliver(int'(w[14:11]), w[16:15], res);
      end
      if (injValid) deliver(int'(injSlot), injIdx, injData);
      if (loadValid) begin
        mWord[loadSlot] = loadWord; mLoaded[loadSlot] = 1;
        mVld[loadSlot] = '0; mFired[loadSlot] = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    flush = 0; loadValid = 0; injValid = 0;
    for (int k = 0; k < n; k++) cycle(tag);
  endtask

  task automatic loadI(input logic [3:0] s, input logic [17:0] w, input string tag);
    loadValid = 1; loadSlot = s; loadWord = w;
    cycle(tag);
    loadValid = 0;
  endtask

  task automatic inject(input logic [3:0] s, input logic [1:0] idx, input logic [15:0] d,
                        input string tag);
    injValid = 1; injSlot = s; injIdx = idx; injData = d;
    cycle(tag);
    injValid = 0;
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    reportEnd();
  end

  initial begin
    int unused;
    unused = $urandom(32'd24681);
    modelReset();
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    // R1: idle out of reset
    check(issueValid == 1'b0, "R1", "reset issueValid", 32'(issueValid), 0);
    idle(2, "R1");

    // R2 R6 R7 R9: ADD at slot 3 feeds move at slot 5
    loadI(4'd5, mkWord(2'd3, 0, 0, 0, 0, 0, 0, 0, 0), "R2");
    loadI(4'd3, mkWord(2'd0, 0, 0, 1, 2'd0, 4'd5, 0, 0, 0), "R2");
    inject(4'd3, 2'd0, 16'd10, "R9");
    check(issueValid == 0, "R9", "issue without right operand", 32'(issueValid), 0);
    idle(2, "R9");
    inject(4'd3, 2'd1, 16'd7, "R2");
    check(issueValid && issueSlot == 4'd3 && issueResult == 16'd17, "R6", "add result",
          {issueSlot, issueResult}, {4'd3, 16'd17});
    cycle("R6");
    check(issueValid && issueSlot == 4'd5 && issueResult == 16'd17, "R7", "forwarded move",
          {issueSlot, issueResult}, {4'd5, 16'd17});
    cycle("R7");
    check(issueValid == 0, "R4", "no second issue", 32'(issueValid), 0);
    idle(2, "R4");

    // R5: move at slot 0 readies slots 2 and 1 together
    loadI(4'd2, mkWord(2'd3, 0, 0, 0, 0, 0, 0, 0, 0), "R5");
    loadI(4'd1, mkWord(2'd3, 0, 0, 0, 0, 0, 0, 0, 0), "R5");
    loadI(4'd0, mkWord(2'd3, 0, 0, 1, 2'd0, 4'd2, 1, 2'd0, 4'd1), "R5");
    inject(4'd0, 2'd0, 16'h00AB, "R5");
    cycle("R5");
    check(issueValid && issueSlot == 4'd1, "R5", "lowest ready first", 32'(issueSlot), 1);
    cycle("R5");
    check(issueValid && issueSlot == 4'd2, "R5", "second ready next", 32'(issueSlot), 2);
    idle(2, "R5");

    // R8: predicate polarity
    loadI(4'd7, mkWord(2'd3, 1, 1, 0, 0, 0, 0, 0, 0), "R8");
    inject(4'd7, 2'd0, 16'd5, "R8");
    inject(4'd7, 2'd2, 16'd0, "R8");
    check(issueValid == 0, "R8", "mismatched predicate", 32'(issueValid), 0);
    idle(3, "R8");
    loadI(4'd8, mkWord(2'd3, 1, 0, 0, 0, 0, 0, 0, 0), "R8");
    inject(4'd8, 2'd2, 16'd2, "R8");
    inject(4'd8, 2'd0, 16'd9, "R8");
    check(issueValid && issueSlot == 4'd8 && issueResult == 16'd9, "R8", "matching predicate",
          {issueSlot, issueResult}, {4'd8, 16'd9});
    idle(1, "R8");

    // R3: index 3 ignored; SUB
    loadI(4'd10, mkWord(2'd1, 0, 0, 0, 0, 0, 0, 0, 0), "R3");
    inject(4'd10, 2'd3, 16'd1, "R3");
    inject(4'd10, 2'd1, 16'd4, "R3");
    check(issueValid == 0, "R3", "index 3 not an operand", 32'(issueValid), 0);
    inject(4'd10, 2'd0, 16'd30, "R3");
    check(issueValid && issueResult == 16'd26, "R6", "sub result", 32'(issueResult), 26);
    idle(1, "R6");

    // R10: flush with simultaneous delivery
    loadI(4'd9, mkWord(2'd3, 0, 0, 0, 0, 0, 0, 0, 0), "R10");
    flush = 1; injValid = 1; injSlot = 4'd9; injIdx = 2'd0; injData = 16'd3;
    cycle("R10");
    flush = 0; injValid = 0;
    check(issueValid == 0, "R10", "after flush", 32'(issueValid), 0);
    inject(4'd9, 2'd0, 16'd3, "R10");
    check(issueValid == 0, "R10", "emptied slot stays quiet", 32'(issueValid), 0);
    idle(2, "R10");

    // R11: injection beats forward; load beats delivery
    loadI(4'd12, mkWord(2'd3, 0, 0, 0, 0, 0, 0, 0, 0), "R11");
    loadI(4'd11, mkWord(2'd3, 0, 0, 1, 2'd0, 4'd12, 0, 0, 0), "R11");
    inject(4'd11, 2'd0, 16'd1, "R11");
    inject(4'd12, 2'd0, 16'h0055, "R11");
    check(issueValid && issueSlot == 4'd12 && issueResult == 16'h0055, "R11",
          "injected value wins", {issueSlot, issueResult}, {4'd12, 16'h0055});
    idle(1, "R11");
    loadValid = 1; loadSlot = 4'd13; loadWord = mkWord(2'd3, 0, 0, 0, 0, 0, 0, 0, 0);
    injValid = 1; injSlot = 4'd13; injIdx = 2'd0; injData = 16'd8;
    cycle("R11");
    loadValid = 0; injValid = 0;
    check(issueValid == 0, "R11", "load wins over delivery", 32'(issueValid), 0);
    idle(2, "R11");

    // random phase: every cycle compared with the model (R4 R5 R6 R7 R8 R10)
    for (int n = 0; n < 4000; n++) begin
      flush     = ($urandom % 64) == 0;
      loadValid = ($urandom % 5) == 0;
      loadSlot  = 4'($urandom);
      loadWord  = 18'($urandom);
      injValid  = ($urandom % 5) < 3;
      injSlot   = 4'($urandom);
      injIdx    = 2'($urandom);
      injData   = 16'($urandom);
      cycle("R5 R6 random");
    end
    idle(4, "R4");
    reportEnd();
  end
endmodule